// File: doc/BRIEF.md
# Vector Playback Clock Selection and Run Control

This block decides when a parallel test-pattern player steps to its next vector. It makes a one-cycle advance pulse for the vector sequencer. Every signal in the block is timed by a single reference clock. An advance can follow one of two sources, picked by a mode input. The first is an internal clock, made by dividing the reference by one of four programmable ratios. The second is the rising edge of an external drive clock. The internal clock is also sent out on a pin, so the device under test can run from it.

Playback is controlled by three qualifier inputs: a start request, a stop request and an enable level. An optional arm step holds off a start until a host arm command arrives, so that driving and response capture begin together. When the sequencer reports its last vector, or a stop edge arrives, playback ends. A host clear returns the block to idle. The block also makes a capture strobe for the input section. The strobe comes from a bit that the vector file sets, so capture stays aligned with the driven vectors.

Top module: `vecdrv_clk_ctrl`

## Requirements
- R1: While and directly after reset, run_state is 0 (idle), and adv_pulse and cap_strobe are low. The run_state codes are: 0 idle, 1 armed, 2 running, 3 done.
- R2: int_clk_out is the reference divided by DIV0, DIV1, DIV2 or DIV3 (defaults 2, 4, 8, 40), for rate_sel values 0, 1, 2 and 3. It is high for half of each period.
- R3: When src_ext is 0, one advance is made per internal clock period. When src_ext is 1, one advance is made per rising edge of ext_clk, taken after a two-stage synchronizer, and the internal clock has no effect.
- R4: When arm_mode is 0 and the block is idle, a rising edge on start_in is held pending. Running (2) starts, together with the first adv_pulse, at the first clock event at which enable_in is high.
- R5: A start request has no effect while enable_in is low. While running, a clock event with enable_in low gives no adv_pulse.
- R6: A rising edge on stop_in while running moves the block to done (3). No further adv_pulse follows.
- R7: A high end_of_vec while running moves the block to done (3). No further adv_pulse follows.
- R8: When arm_mode is 1 and the block is idle, start edges are ignored. An arm_cmd pulse moves the block to armed (1), and only from there is a start edge acted on.
- R9: A host_clr pulse returns the block to idle (0) from any state on the next cycle. It also discards any pending start.
- R10: cap_strobe goes high for one cycle, directly after an adv_pulse cycle in which cap_bit was high. It never goes high at any other time.
- R11: The done state holds until host_clr, whatever happens on start_in and on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Internal rate select |
| src_ext | input | 1 | 1 selects the external drive clock |
| ext_clk | input | 1 | External drive clock (asynchronous) |
| start_in | input | 1 | Start request (asynchronous, edge) |
| stop_in | input | 1 | Stop request (asynchronous, edge) |
| enable_in | input | 1 | Enable qualifier (asynchronous, level) |
| arm_mode | input | 1 | 1 selects armed start |
| arm_cmd | input | 1 | Host arm pulse |
| host_clr | input | 1 | Host clear pulse, back to idle |
| end_of_vec | input | 1 | Sequencer reports its last vector |
| cap_bit | input | 1 | Capture bit of the vector being driven |
| int_clk_out | output | 1 | Divided internal clock, sent out on a pin |
| adv_pulse | output | 1 | One-cycle vector advance enable |
| cap_strobe | output | 1 | Capture strobe for the input section |
| run_state | output | 2 | Run state code |

## Verification
The bench builds the block with its default parameters: divide ratios 2, 4, 8 and 40, and two synchronizer stages. This puts every internal rate within reach, including the slowest, over windows of 120 reference cycles, in which each ratio gives a whole number of periods. The scoreboard predicts the gap between advances for each source: 8 cycles for rate select 2, and 6 cycles for an external clock that toggles every third cycle. A stop, an enable drop or an end-of-vectors is applied just after an advance, and there is then enough slack to show that the next advance is suppressed.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } run_st_e;

    // Asynchronous qualifiers, in synchronizer bit order (MSB first)
    typedef struct packed {
        logic ext_clk;
        logic start;
        logic stop;
        logic enable;
    } qual_t;

    localparam int NUM_QUAL = $bits(qual_t);
    // 1 = bit is edge-detected, 0 = bit is passed as a level
    localparam logic [NUM_QUAL-1:0] QUAL_EDGE_MASK = 4'b1110;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int pick_div(input logic [1:0] sel, input int d0, input int d1,
                                    input int d2, input int d3);
        case (sel)
            2'd0:    return d0;
            2'd1:    return d1;
            2'd2:    return d2;
            default: return d3;
        endcase
    endfunction

endpackage

// File: rtl/vdc_rate_gen.sv
module vdc_rate_gen
    import vdc_pkg::*;
#(
    parameter int DIV0 = 2,
    parameter int DIV1 = 4,
    parameter int DIV2 = 8,
    parameter int DIV3 = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       tick,
    output logic       int_clk
);
    localparam int MAXDIV = max4(DIV0, DIV1, DIV2, DIV3);
    localparam int CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] half_cnt;

    always_comb begin
        last_cnt = CW'(pick_div(rate_sel, DIV0, DIV1, DIV2, DIV3) - 1);
        half_cnt = CW'(pick_div(rate_sel, DIV0, DIV1, DIV2, DIV3) / 2);
    end

    // ">=" lets a rate change to a shorter period wrap without a runt
    assign tick    = (cnt >= last_cnt);
    assign int_clk = (cnt < half_cnt);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_INT_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(int_clk) |-> $past(tick)); // R2

endmodule

// File: rtl/vdc_sync_bit.sv
module vdc_sync_bit #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic o
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    generate
        if (EDGE) begin : g_edge
            logic last;
            always_ff @(posedge clk) begin
                if (rst) last <= 1'b0;
                else     last <= sh[STAGES-1];
            end
            assign o = sh[STAGES-1] & ~last;
        end else begin : g_level
            assign o = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/vdc_run_fsm.sv
module vdc_run_fsm
    import vdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_mode,
    input  logic       arm_cmd,
    input  logic       host_clr,
    input  logic       start_rise,
    input  logic       stop_rise,
    input  logic       enable_q,
    input  logic       clk_evt,
    input  logic       end_of_vec,
    input  logic       cap_bit,
    output run_st_e    state,
    output logic       adv_pulse,
    output logic       cap_strobe
);
    run_st_e st_n;
    logic    pend, pend_n, adv_n, go;

    always_comb begin
        st_n   = state;
        pend_n = pend;
        adv_n  = 1'b0;
        go     = (pend | start_rise) & enable_q & clk_evt;
        if (host_clr) begin
            st_n   = ST_IDLE;
            pend_n = 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arm_mode) begin
                        pend_n = 1'b0;
                        if (arm_cmd) st_n = ST_ARMED;
                    end else if (go) begin
                        st_n   = ST_RUN;
                        pend_n = 1'b0;
                        adv_n  = 1'b1;
                    end else if (start_rise) begin
                        pend_n = 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (go) begin
                        st_n   = ST_RUN;
                        pend_n = 1'b0;
                        adv_n  = 1'b1;
                    end else if (start_rise) begin
                        pend_n = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (stop_rise || end_of_vec) st_n  = ST_DONE;
                    else if (clk_evt && enable_q) adv_n = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pend       <= 1'b0;
            adv_pulse  <= 1'b0;
            cap_strobe <= 1'b0;
        end else begin
            state      <= st_n;
            pend       <= pend_n;
            adv_pulse  <= adv_n;
            cap_strobe <= adv_pulse & cap_bit;
        end
    end

    AST_ADV_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        adv_pulse |-> (state == ST_RUN)); // R5
    AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_rise && !host_clr) |=> (state == ST_DONE && !adv_pulse)); // R6
    AST_EOV_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && end_of_vec && !host_clr) |=> (state == ST_DONE)); // R7
    AST_ARMED_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(arm_cmd)); // R8
    AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        host_clr |=> (state == ST_IDLE)); // R9
    AST_CAP_AFTER_ADV: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |-> $past(adv_pulse)); // R10
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !host_clr) |=> (state == ST_DONE)); // R11

endmodule

// File: rtl/vecdrv_clk_ctrl.sv
module vecdrv_clk_ctrl
    import vdc_pkg::*;
#(
    parameter int DIV0        = 2,
    parameter int DIV1        = 4,
    parameter int DIV2        = 8,
    parameter int DIV3        = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic       src_ext,
    input  logic       ext_clk,
    input  logic       start_in,
    input  logic       stop_in,
    input  logic       enable_in,
    input  logic       arm_mode,
    input  logic       arm_cmd,
    input  logic       host_clr,
    input  logic       end_of_vec,
    input  logic       cap_bit,
    output logic       int_clk_out,
    output logic       adv_pulse,
    output logic       cap_strobe,
    output logic [1:0] run_state
);
    qual_t   raw_q, cond_q;
    logic    int_tick, clk_evt;
    run_st_e st;

    assign raw_q = '{ext_clk: ext_clk, start: start_in, stop: stop_in, enable: enable_in};

    generate
        for (genvar b = 0; b < NUM_QUAL; b++) begin : g_qual
            vdc_sync_bit #(
                .STAGES (SYNC_STAGES),
                .EDGE   (QUAL_EDGE_MASK[b])
            ) i_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw_q[b]),
                .o   (cond_q[b])
            );
        end
    endgenerate

    vdc_rate_gen #(
        .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
    ) i_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .tick     (int_tick),
        .int_clk  (int_clk_out)
    );

    assign clk_evt = src_ext ? cond_q.ext_clk : int_tick;

    vdc_run_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .arm_mode   (arm_mode),
        .arm_cmd    (arm_cmd),
        .host_clr   (host_clr),
        .start_rise (cond_q.start),
        .stop_rise  (cond_q.stop),
        .enable_q   (cond_q.enable),
        .clk_evt    (clk_evt),
        .end_of_vec (end_of_vec),
        .cap_bit    (cap_bit),
        .state      (st),
        .adv_pulse  (adv_pulse),
        .cap_strobe (cap_strobe)
    );

    assign run_state = st;

    AST_SRC_EXT_NO_TICK_ADV: assert property (@(posedge clk) disable iff (rst)
        (src_ext && $past(src_ext) && $past(st) == ST_RUN && !$past(cond_q.ext_clk))
        |-> !adv_pulse); // R3

endmodule

// File: tb/test_vecdrv_clk_ctrl.sv
module test_vecdrv_clk_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       src_ext = 1'b0, ext_clk = 1'b0;
    logic       start_in = 1'b0, stop_in = 1'b0, enable_in = 1'b0;
    logic       arm_mode = 1'b0, arm_cmd = 1'b0, host_clr = 1'b0;
    logic       end_of_vec = 1'b0, cap_bit = 1'b0;
    logic       int_clk_out, adv_pulse, cap_strobe;
    logic [1:0] run_state;

    vecdrv_clk_ctrl i_vecdrv_clk_ctrl (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .src_ext(src_ext), .ext_clk(ext_clk),
        .start_in(start_in), .stop_in(stop_in), .enable_in(enable_in),
        .arm_mode(arm_mode), .arm_cmd(arm_cmd), .host_clr(host_clr),
        .end_of_vec(end_of_vec), .cap_bit(cap_bit), .int_clk_out(int_clk_out),
        .adv_pulse(adv_pulse), .cap_strobe(cap_strobe), .run_state(run_state)
    );

    always #10 clk = ~clk;

    int errs = 0, checks = 0, cyc = 0, adv_total = 0, last_adv = 0;
    bit seg_first = 1'b0, prev_capq = 1'b0, finished = 1'b0, ext_on = 1'b0;
    int exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected advance gaps, checks capture strobe timing
    always @(negedge clk) begin
        int e;
        if (!rst) begin
            if (cap_strobe || prev_capq)
                check(cap_strobe == prev_capq, "R10", "cap_strobe", cap_strobe, prev_capq);
            prev_capq = adv_pulse && cap_bit;
            if (adv_pulse) begin
                adv_total++;
                if (seg_first) seg_first = 1'b0;
                else if (exp_q.size() == 0) check(1'b0, "R6", "unexpected advance", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    check((cyc - last_adv) == e, "R3", "advance gap", cyc - last_adv, e);
                end
                last_adv = cyc;
            end
        end
    end

    // External drive clock: toggles every third reference cycle
    initial begin
        int ecnt = 0;
        forever begin
            @(posedge clk); #2;
            if (ext_on) begin
                ecnt++;
                if (ecnt == 3) begin ext_clk = ~ext_clk; ecnt = 0; end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // sel: 0 start, 1 stop, 2 clear, 3 arm, 4 end of vectors
    task automatic pulse(input int sel);
        step(1);
        case (sel)
            0: start_in = 1'b1;
            1: stop_in = 1'b1;
            2: host_clr = 1'b1;
            3: arm_cmd = 1'b1;
            default: end_of_vec = 1'b1;
        endcase
        step(1);
        start_in = 1'b0; stop_in = 1'b0; host_clr = 1'b0; arm_cmd = 1'b0; end_of_vec = 1'b0;
    endtask

    task automatic seg(input int gap, input int n);
        seg_first = 1'b1;
        exp_q.delete();
        repeat (n - 1) exp_q.push_back(gap);
    endtask

    task automatic wait_adv(input int target, input string req);
        int n = 0;
        while (adv_total < target && n < 3000) begin @(negedge clk); n++; end
        if (adv_total < target) check(1'b0, req, "advance count timeout", adv_total, target);
    endtask

    task automatic chk_state(input int exp, input string req);
        @(negedge clk);
        check(run_state == 2'(exp), req, "run_state", run_state, exp);
    endtask

    task automatic rate_check(input int sel, input int d);
        int rises = 0, highs = 0;
        bit prev;
        step(1); rate_sel = 2'(sel);
        repeat (50) @(negedge clk);
        prev = int_clk_out;
        repeat (120) begin
            @(negedge clk);
            if (int_clk_out && !prev) rises++;
            if (int_clk_out) highs++;
            prev = int_clk_out;
        end
        check(rises == 120 / d, "R2", "int clock periods", rises, 120 / d);
        check(highs == 60, "R2", "int clock high samples", highs, 60);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        int base;
        step(5);
        @(negedge clk);
        check(run_state == 2'd0, "R1", "state in reset", run_state, 0);
        check(adv_pulse == 1'b0, "R1", "adv in reset", adv_pulse, 0);
        step(1); rst = 1'b0;
        @(negedge clk);
        check(adv_pulse == 1'b0 && cap_strobe == 1'b0, "R1", "outputs after reset",
              adv_pulse | cap_strobe, 0);
        chk_state(0, "R1");

        rate_check(0, 2); rate_check(1, 4); rate_check(2, 8); rate_check(3, 40);

        // Immediate mode, internal rate /8, with capture bit set
        step(1); rate_sel = 2'd2; enable_in = 1'b1; cap_bit = 1'b1;
        base = adv_total;
        seg(8, 6);
        pulse(0);
        wait_adv(base + 6, "R4");
        chk_state(2, "R4");
        pulse(1);
        step(40);
        chk_state(3, "R6");
        check(adv_total == base + 6, "R6", "advances after stop", adv_total, base + 6);
        check(exp_q.size() == 0, "R3", "gaps left over", exp_q.size(), 0);
        pulse(0); step(60);
        chk_state(3, "R11");
        check(adv_total == base + 6, "R11", "advances while done", adv_total, base + 6);
        pulse(2);
        chk_state(0, "R9");

        // Enable low blocks start; clear discards the pending start
        step(1); enable_in = 1'b0;
        base = adv_total;
        pulse(0); step(60);
        chk_state(0, "R5");
        pulse(2);
        step(1); enable_in = 1'b1;
        step(60);
        chk_state(0, "R9");
        check(adv_total == base, "R9", "advances after cleared start", adv_total, base);

        // Enable drop mid-run, then end of vectors
        seg(8, 3);
        pulse(0);
        wait_adv(base + 3, "R4");
        step(1); enable_in = 1'b0;
        step(60);
        chk_state(2, "R5");
        check(adv_total == base + 3, "R5", "advances with enable low", adv_total, base + 3);
        seg(8, 3);
        step(1); enable_in = 1'b1;
        wait_adv(base + 6, "R5");
        pulse(4);
        step(40);
        chk_state(3, "R7");
        check(adv_total == base + 6, "R7", "advances after end", adv_total, base + 6);
        pulse(2);

        // Armed mode, capture bit clear
        step(1); arm_mode = 1'b1; cap_bit = 1'b0;
        base = adv_total;
        pulse(0); step(40);
        chk_state(0, "R8");
        check(adv_total == base, "R8", "advances before arm", adv_total, base);
        pulse(3);
        chk_state(1, "R8");
        step(30);
        chk_state(1, "R8");
        seg(8, 3);
        pulse(0);
        wait_adv(base + 3, "R8");
        chk_state(2, "R8");
        pulse(2);
        chk_state(0, "R9");
        step(1); arm_mode = 1'b0;

        // External drive clock; internal ticks must not advance
        step(1); src_ext = 1'b1; rate_sel = 2'd0; cap_bit = 1'b1;
        base = adv_total;
        pulse(0); step(60);
        chk_state(0, "R3");
        check(adv_total == base, "R3", "advances without ext edges", adv_total, base);
        seg(6, 5);
        step(1); ext_on = 1'b1;
        wait_adv(base + 5, "R3");
        pulse(1);
        step(40);
        chk_state(3, "R6");
        check(adv_total == base + 5, "R6", "ext advances after stop", adv_total, base + 5);
        check(exp_q.size() == 0, "R3", "ext gaps left over", exp_q.size(), 0);
        pulse(2);
        chk_state(0, "R9");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule